// File: doc/BRIEF.md
# Five-Slot Shader Issue Bundle Packer

This block sits in front of one shader unit whose arithmetic stage has five slots per clock: four thin general-purpose lanes (slots 0 to 3) and one wide lane (slot 4) that can also run transcendental functions. Each clock it looks at a window of upcoming scalar micro-operations in program order. It places as many of them as the slot rules and register dependencies allow into one issue bundle, which appears on the output one clock later.

Packing is strictly in order. The first window entry that cannot be placed ends the bundle, and so does the first entry that is not valid. That entry and all entries behind it wait for a later clock. An entry is not placed if it reads a register written by an earlier entry in the same window. A fully dependent chain therefore issues one operation per clock, while independent work can fill all five slots. Dot products take a group of thin lanes at once. Conversions take one slot per channel. Transcendentals and reciprocals go only to the wide lane. A reciprocal keeps the wide lane for a second clock, and the whole input is stalled during that clock.

Top module: `vliw_slot_packer`

## Requirements
- R1: A synchronous active-low reset empties the output bundle (all slot valids low, out_eob low) and cancels any pending wide-lane hold. A reciprocal presented in a reset cycle leaves no hold, so the first clock after reset accepts a single-slot operation.
- R2: Operations accepted in one cycle (in_ready high) appear in their slots on the outputs after the next rising edge. out_eob is high exactly when that bundle has at least one valid slot, and stays low after a cycle with nothing accepted.
- R3: A window entry is not accepted in the same cycle as an earlier window entry whose destination index equals one of its enabled source indices. A chain in which each operation reads the previous result issues one operation per cycle.
- R4: General operations (class code 0) take the lowest-numbered free slot, so thin slots 0 to 3 fill before wide slot 4. Five independent general operations fill all five slots in one bundle.
- R5: Transcendental operations (class code 1) are placed only in slot 4. A second one in the same window ends the bundle.
- R6: A reciprocal (class code 2) is placed only in slot 4. In the following cycle in_ready is all zero and the emitted bundle is empty.
- R7: A dot product (class code 3) of width in_wm1+1 takes that many of the lowest free thin slots, each showing the same class and destination. If fewer thin slots are free, the bundle ends.
- R8: A conversion (class code 4) of in_wm1+1 channels takes that many of the lowest free slots of any kind, the wide slot included.
- R9: in_ready is always a prefix of the window. Lane i is ready only if lane i-1 is ready. The first lane that is invalid or cannot be placed ends the bundle, even if valid lanes follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | WIN | Per-lane valid for the window; lane 0 is the oldest |
| in_ready | output | WIN | Per-lane accept for this cycle |
| in_cls | input | 3*WIN | Class code of lane i at bits [3i+2:3i] |
| in_dst | input | RW*WIN | Destination register of lane i at bits [RW*i+RW-1:RW*i] |
| in_src | input | 3*RW*WIN | Source k of lane i at bits starting at RW*(3i+k) |
| in_srcv | input | 3*WIN | Source enables; bit 3i+k enables source k of lane i |
| in_wm1 | input | 2*WIN | Channel count minus one for dot products and conversions |
| out_vld | output | NTHIN+1 | Per-slot valid of the emitted bundle; top bit is the wide slot |
| out_cls | output | 3*(NTHIN+1) | Per-slot class code, zero in empty slots |
| out_dst | output | RW*(NTHIN+1) | Per-slot destination register, zero in empty slots |
| out_eob | output | 1 | Bundle strobe: the emitted bundle is not empty |

## Verification
The bench builds the packer with a window of five entries, four thin lanes and six-bit register indices. Because the window is exactly as wide as the slot row, a fully packed bundle can be reached. Because the thin lanes number four, a width-four dot product claims every thin lane while the wide lane stays free for a general operation. Six-bit indices leave room to keep the source registers of independent streams apart from every destination used in a test, so a dependency only stalls where a test intends one.

// File: rtl/vpk_pkg.sv
// Package: shared encodings for the bundle packer.
// Assumes a 3-bit class field and three source operands per micro-op.
package vpk_pkg;
    localparam int CLS_W = 3;
    localparam int SRC_N = 3;

    typedef enum logic [CLS_W-1:0] {
        OPC_ALU   = 3'd0,
        OPC_TRANS = 3'd1,
        OPC_RECIP = 3'd2,
        OPC_DOT   = 3'd3,
        OPC_CVT   = 3'd4
    } opc_e;
endpackage

// File: rtl/vpk_hazard.sv
// Module: read-after-write detector across the input window.
// Flags a lane whose enabled source matches the destination of any
// older valid lane. Because packing is in order, an older lane that
// is not placed already stops this lane, so comparing against all
// older lanes gives the same result as comparing against placed ones.
module vpk_hazard
    import vpk_pkg::*;
#(
    parameter int WIN = 5,
    parameter int RW  = 6
) (
    input  logic [WIN-1:0]            in_valid,
    input  logic [WIN*RW-1:0]         in_dst,
    input  logic [WIN*SRC_N*RW-1:0]   in_src,
    input  logic [WIN*SRC_N-1:0]      in_srcv,
    output logic [WIN-1:0]            hazard
);

    // Purpose: compare every enabled source of each lane with older destinations.
    always_comb begin
        hazard = '0;
        for (int i = 0; i < WIN; i++) begin
            for (int j = 0; j < WIN; j++) begin
                if (j < i && in_valid[j]) begin
                    for (int k = 0; k < SRC_N; k++) begin
                        if (in_srcv[i*SRC_N+k] &&
                            in_src[(i*SRC_N+k)*RW +: RW] == in_dst[j*RW +: RW]) begin
                            hazard[i] = 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vpk_alloc.sv
// Module: in-order slot allocator.
// Walks the window oldest first, giving each entry the lowest free
// slots its class may use; the first failure closes the bundle.
// Assumes slots 0..NTHIN-1 are thin lanes and slot NTHIN is the wide lane.
module vpk_alloc
    import vpk_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int NTHIN = 4,
    parameter int RW    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIN-1:0]              in_valid,
    input  logic [WIN-1:0]              hazard,
    input  logic [WIN*CLS_W-1:0]        in_cls,
    input  logic [WIN*RW-1:0]           in_dst,
    input  logic [WIN*2-1:0]            in_wm1,
    input  logic                        wide_busy,
    output logic [WIN-1:0]              take,
    output logic [NTHIN:0]              slot_vld,
    output logic [(NTHIN+1)*CLS_W-1:0]  slot_cls,
    output logic [(NTHIN+1)*RW-1:0]     slot_dst,
    output logic                        recip_issued
);

    localparam int NS = NTHIN + 1;
    localparam logic [NS-1:0] WIDE_M = {1'b1, {NTHIN{1'b0}}};
    localparam logic [NS-1:0] THIN_M = {1'b0, {NTHIN{1'b1}}};
    localparam logic [NS-1:0] ALL_M  = {NS{1'b1}};

    // Pick the n lowest set bits of m.
    function automatic logic [NS-1:0] pick_slots(input logic [NS-1:0] m, input logic [2:0] n);
        logic [NS-1:0] r;
        int c;
        r = '0;
        c = 0;
        for (int s = 0; s < NS; s++) begin
            if (m[s] && c < int'(n)) begin
                r[s] = 1'b1;
                c++;
            end
        end
        return r;
    endfunction

    // Purpose: place window entries in order until one does not fit.
    always_comb begin
        logic [NS-1:0]    free_m;
        logic [NS-1:0]    allow;
        logic [NS-1:0]    grab;
        logic [2:0]       need;
        logic [CLS_W-1:0] cls_v;
        logic             stop;
        free_m       = wide_busy ? THIN_M : ALL_M;
        stop         = wide_busy;
        take         = '0;
        slot_vld     = '0;
        slot_cls     = '0;
        slot_dst     = '0;
        recip_issued = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            cls_v = in_cls[i*CLS_W +: CLS_W];
            if (cls_v == OPC_TRANS || cls_v == OPC_RECIP) begin
                allow = WIDE_M;
            end else if (cls_v == OPC_DOT) begin
                allow = THIN_M;
            end else begin
                allow = ALL_M;
            end
            if (cls_v == OPC_DOT || cls_v == OPC_CVT) begin
                need = {1'b0, in_wm1[i*2 +: 2]} + 3'd1;
            end else begin
                need = 3'd1;
            end
            grab = pick_slots(free_m & allow, need);
            if (!stop && in_valid[i] && !hazard[i] && ($countones(grab) == int'(need))) begin
                take[i] = 1'b1;
                free_m  = free_m & ~grab;
                for (int s = 0; s < NS; s++) begin
                    if (grab[s]) begin
                        slot_vld[s]               = 1'b1;
                        slot_cls[s*CLS_W +: CLS_W] = cls_v;
                        slot_dst[s*RW +: RW]       = in_dst[i*RW +: RW];
                    end
                end
                if (cls_v == OPC_RECIP) begin
                    recip_issued = 1'b1;
                end
            end else begin
                stop = 1'b1;
            end
        end
    end

    // Acceptance must be a prefix of the window (R9).
    generate
        for (genvar g = 1; g < WIN; g++) begin : g_prefix
            assert_ready_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
                take[g] |-> take[g-1]);
        end
    endgenerate

endmodule

// File: rtl/vpk_bundle_reg.sv
// Module: output bundle register and wide-lane hold flag.
// Captures the bundle built this cycle; the hold flag marks the cycle
// after a reciprocal issue. Synchronous active-low reset clears both.
module vpk_bundle_reg
    import vpk_pkg::*;
#(
    parameter int NTHIN = 4,
    parameter int RW    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NTHIN:0]              d_vld,
    input  logic [(NTHIN+1)*CLS_W-1:0]  d_cls,
    input  logic [(NTHIN+1)*RW-1:0]     d_dst,
    input  logic                        d_recip,
    output logic [NTHIN:0]              q_vld,
    output logic [(NTHIN+1)*CLS_W-1:0]  q_cls,
    output logic [(NTHIN+1)*RW-1:0]     q_dst,
    output logic                        q_eob,
    output logic                        q_busy
);

    localparam int NS = NTHIN + 1;

    generate
        for (genvar s = 0; s < NS; s++) begin : g_slot
            // Purpose: hold one slot of the issued bundle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_vld[s]               <= 1'b0;
                    q_cls[s*CLS_W +: CLS_W] <= '0;
                    q_dst[s*RW +: RW]       <= '0;
                end else begin
                    q_vld[s]               <= d_vld[s];
                    q_cls[s*CLS_W +: CLS_W] <= d_cls[s*CLS_W +: CLS_W];
                    q_dst[s*RW +: RW]       <= d_dst[s*RW +: RW];
                end
            end

            if (s < NTHIN) begin : g_thin_chk
                // Wide-only classes never land in a thin slot (R5, R6).
                assert_thin_no_wide_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    q_vld[s] |-> (q_cls[s*CLS_W +: CLS_W] != OPC_TRANS &&
                                  q_cls[s*CLS_W +: CLS_W] != OPC_RECIP));
            end
        end
    endgenerate

    // Purpose: bundle strobe and one-cycle wide-lane hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_eob  <= 1'b0;
            q_busy <= 1'b0;
        end else begin
            q_eob  <= |d_vld;
            q_busy <= d_recip;
        end
    end

    // A hold lasts exactly one cycle (R6).
    assert_hold_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_busy |=> !q_busy);

endmodule

// File: rtl/vliw_slot_packer.sv
// Module: top of the five-slot issue bundle packer.
// Takes a window of WIN in-order micro-ops per clock, reports how many
// were accepted through in_ready, and emits the packed bundle one clock
// later. Assumes the upstream shifts its window by the accepted count.
module vliw_slot_packer
    import vpk_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int NTHIN = 4,
    parameter int RW    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WIN-1:0]                in_valid,
    output logic [WIN-1:0]                in_ready,
    input  logic [WIN*3-1:0]              in_cls,
    input  logic [WIN*RW-1:0]             in_dst,
    input  logic [WIN*3*RW-1:0]           in_src,
    input  logic [WIN*3-1:0]              in_srcv,
    input  logic [WIN*2-1:0]              in_wm1,
    output logic [NTHIN:0]                out_vld,
    output logic [(NTHIN+1)*3-1:0]        out_cls,
    output logic [(NTHIN+1)*RW-1:0]       out_dst,
    output logic                          out_eob
);

    localparam int NS = NTHIN + 1;

    logic [WIN-1:0]          hazard;
    logic [NS-1:0]           slot_vld;
    logic [NS*CLS_W-1:0]     slot_cls;
    logic [NS*RW-1:0]        slot_dst;
    logic                    recip_issued;
    logic                    wide_busy;

    vpk_hazard #(.WIN(WIN), .RW(RW)) u_hazard (
        .in_valid (in_valid),
        .in_dst   (in_dst),
        .in_src   (in_src),
        .in_srcv  (in_srcv),
        .hazard   (hazard)
    );

    vpk_alloc #(.WIN(WIN), .NTHIN(NTHIN), .RW(RW)) u_alloc (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .hazard       (hazard),
        .in_cls       (in_cls),
        .in_dst       (in_dst),
        .in_wm1       (in_wm1),
        .wide_busy    (wide_busy),
        .take         (in_ready),
        .slot_vld     (slot_vld),
        .slot_cls     (slot_cls),
        .slot_dst     (slot_dst),
        .recip_issued (recip_issued)
    );

    vpk_bundle_reg #(.NTHIN(NTHIN), .RW(RW)) u_breg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_vld   (slot_vld),
        .d_cls   (slot_cls),
        .d_dst   (slot_dst),
        .d_recip (recip_issued),
        .q_vld   (out_vld),
        .q_cls   (out_cls),
        .q_dst   (out_dst),
        .q_eob   (out_eob),
        .q_busy  (wide_busy)
    );

    // A lane reading an older lane's result is never accepted with it (R3).
    assert_no_dep_coissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard & in_ready) == '0);

    // Input is stalled while the wide lane is held (R6).
    assert_stall_on_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wide_busy |-> (in_ready == '0));

    // Any acceptance yields a bundle strobe one clock later (R2).
    assert_accept_gives_eob_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_ready) |=> out_eob);

endmodule

// File: tb/test_vliw_slot_packer.sv
module test_vliw_slot_packer;
    localparam int WIN   = 5;
    localparam int NTHIN = 4;
    localparam int RW    = 6;
    localparam int NS    = NTHIN + 1;

    localparam logic [2:0] C_ALU = 3'd0, C_TRN = 3'd1, C_RCP = 3'd2, C_DOT = 3'd3, C_CVT = 3'd4;

    typedef struct packed {
        logic       v;
        logic [2:0] c;
        logic [5:0] d;
        logic [5:0] s0;
        logic [5:0] s1;
        logic [2:0] sv;
        logic [1:0] w;
    } op_t;

    typedef struct {
        string          req;
        logic [NS-1:0]  vld;
        logic [NS*3-1:0]  cls;
        logic [NS*RW-1:0] dst;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIN-1:0]        in_valid;
    logic [WIN-1:0]        in_ready;
    logic [WIN*3-1:0]      in_cls;
    logic [WIN*RW-1:0]     in_dst;
    logic [WIN*3*RW-1:0]   in_src;
    logic [WIN*3-1:0]      in_srcv;
    logic [WIN*2-1:0]      in_wm1;
    logic [NS-1:0]         out_vld;
    logic [NS*3-1:0]       out_cls;
    logic [NS*RW-1:0]      out_dst;
    logic                  out_eob;

    int n_chk = 0;
    int n_fail = 0;
    op_t  stim[$];
    exp_t exp_q[$];
    int   acc = 0;
    bit   prev_act = 1'b0;

    always #5 clk = ~clk;

    vliw_slot_packer #(.WIN(WIN), .NTHIN(NTHIN), .RW(RW)) i_vliw_slot_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src(in_src), .in_srcv(in_srcv),
        .in_wm1(in_wm1), .out_vld(out_vld), .out_cls(out_cls), .out_dst(out_dst),
        .out_eob(out_eob)
    );

    function automatic op_t mk(logic [2:0] c, logic [5:0] d, logic [5:0] s0,
                               logic [5:0] s1, logic [2:0] sv, logic [1:0] w);
        op_t o;
        o.v = 1'b1; o.c = c; o.d = d; o.s0 = s0; o.s1 = s1; o.sv = sv; o.w = w;
        return o;
    endfunction

    function automatic op_t hole();
        op_t o;
        o = '0;
        return o;
    endfunction

    function automatic exp_t ex(string r);
        exp_t e;
        e.req = r; e.vld = '0; e.cls = '0; e.dst = '0;
        return e;
    endfunction

    function automatic exp_t sl(exp_t e, int s, logic [2:0] c, logic [5:0] d);
        exp_t r;
        r = e;
        r.vld[s] = 1'b1;
        r.cls[s*3 +: 3] = c;
        r.dst[s*RW +: RW] = d;
        return r;
    endfunction

    task automatic check(bit ok, string req, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic clear_inputs();
        in_valid = '0; in_cls = '0; in_dst = '0; in_src = '0; in_srcv = '0; in_wm1 = '0;
    endtask

    task automatic put_lane(int l, op_t o);
        in_valid[l] = o.v;
        in_cls[l*3 +: 3] = o.c;
        in_dst[l*RW +: RW] = o.d;
        in_src[(l*3)*RW +: RW] = o.s0;
        in_src[(l*3+1)*RW +: RW] = o.s1;
        in_srcv[l*3 +: 3] = o.sv;
        in_wm1[l*2 +: 2] = o.w;
    endtask

    // Monitor: compare the emitted bundle with the scoreboard head.
    task automatic monitor();
        exp_t e;
        if (prev_act) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", $sformatf("unexpected bundle vld=%b", out_vld));
            end else begin
                e = exp_q.pop_front();
                check(out_vld == e.vld && out_cls == e.cls && out_dst == e.dst &&
                      out_eob == (|e.vld), e.req,
                      $sformatf("actual vld=%b cls=%h dst=%h eob=%b expected vld=%b cls=%h dst=%h",
                                out_vld, out_cls, out_dst, out_eob, e.vld, e.cls, e.dst));
            end
        end else begin
            check(out_vld == '0 && out_eob == 1'b0, "R2",
                  $sformatf("idle actual vld=%b eob=%b expected 0 0", out_vld, out_eob));
        end
    endtask

    // Driver step: check output, retire accepted ops, present next window.
    task automatic step();
        @(negedge clk);
        monitor();
        for (int k = 0; k < acc; k++) void'(stim.pop_front());
        while (stim.size() > 0 && !stim[0].v) void'(stim.pop_front());
        clear_inputs();
        prev_act = 1'b0;
        for (int l = 0; l < WIN; l++) begin
            if (l < stim.size()) begin
                put_lane(l, stim[l]);
                if (stim[l].v) prev_act = 1'b1;
            end
        end
        #1;
        acc = $countones(in_ready);
    endtask

    task automatic run();
        step();
        while (stim.size() > 0 || exp_q.size() > 0) step();
        step();
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual run still busy, expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        exp_t e;
        clear_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state of the bundle outputs
        check(out_vld == '0 && out_eob == 1'b0 && out_cls == '0 && out_dst == '0, "R1",
              $sformatf("actual vld=%b eob=%b expected 0 0", out_vld, out_eob));
        rst_n = 1'b1;

        // R4: ten independent general ops fill five slots twice
        for (int k = 1; k <= 10; k++) stim.push_back(mk(C_ALU, 6'(k), 6'd40, 6'd41, 3'b011, 2'd0));
        e = ex("R4");
        for (int s = 0; s < 5; s++) e = sl(e, s, C_ALU, 6'(s + 1));
        exp_q.push_back(e);
        e = ex("R4");
        for (int s = 0; s < 5; s++) e = sl(e, s, C_ALU, 6'(s + 6));
        exp_q.push_back(e);
        run();

        // R3: dependent chain issues one per cycle
        stim.push_back(mk(C_ALU, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        for (int k = 2; k <= 4; k++) stim.push_back(mk(C_ALU, 6'(k), 6'(k - 1), 6'd0, 3'b001, 2'd0));
        for (int k = 1; k <= 4; k++) exp_q.push_back(sl(ex("R3"), 0, C_ALU, 6'(k)));
        run();

        // R5: transcendentals only in the wide slot, one per bundle
        stim.push_back(mk(C_TRN, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        stim.push_back(mk(C_TRN, 6'd2, 6'd41, 6'd0, 3'b001, 2'd0));
        stim.push_back(mk(C_ALU, 6'd3, 6'd42, 6'd0, 3'b001, 2'd0));
        exp_q.push_back(sl(ex("R5"), 4, C_TRN, 6'd1));
        exp_q.push_back(sl(sl(ex("R5"), 0, C_ALU, 6'd3), 4, C_TRN, 6'd2));
        run();

        // R6: reciprocal holds the wide lane and stalls the next cycle
        stim.push_back(mk(C_RCP, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        for (int k = 2; k <= 6; k++) stim.push_back(mk(C_ALU, 6'(k), 6'd41, 6'd0, 3'b001, 2'd0));
        e = sl(ex("R6"), 4, C_RCP, 6'd1);
        for (int s = 0; s < 4; s++) e = sl(e, s, C_ALU, 6'(s + 2));
        exp_q.push_back(e);
        exp_q.push_back(ex("R6"));
        exp_q.push_back(sl(ex("R6"), 0, C_ALU, 6'd6));
        run();

        // R7: dot products need a group of free thin lanes
        stim.push_back(mk(C_ALU, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        stim.push_back(mk(C_DOT, 6'd2, 6'd41, 6'd42, 3'b011, 2'd3));
        stim.push_back(mk(C_ALU, 6'd3, 6'd43, 6'd0, 3'b001, 2'd0));
        stim.push_back(mk(C_DOT, 6'd4, 6'd44, 6'd45, 3'b011, 2'd1));
        stim.push_back(mk(C_TRN, 6'd5, 6'd46, 6'd0, 3'b001, 2'd0));
        exp_q.push_back(sl(ex("R7"), 0, C_ALU, 6'd1));
        e = sl(ex("R7"), 4, C_ALU, 6'd3);
        for (int s = 0; s < 4; s++) e = sl(e, s, C_DOT, 6'd2);
        exp_q.push_back(e);
        exp_q.push_back(sl(sl(sl(ex("R7"), 0, C_DOT, 6'd4), 1, C_DOT, 6'd4), 4, C_TRN, 6'd5));
        run();

        // R8: conversions take one slot per channel, wide slot allowed
        stim.push_back(mk(C_CVT, 6'd1, 6'd40, 6'd0, 3'b001, 2'd2));
        stim.push_back(mk(C_CVT, 6'd2, 6'd41, 6'd0, 3'b001, 2'd1));
        stim.push_back(mk(C_ALU, 6'd3, 6'd42, 6'd0, 3'b001, 2'd0));
        e = ex("R8");
        for (int s = 0; s < 3; s++) e = sl(e, s, C_CVT, 6'd1);
        e = sl(sl(e, 3, C_CVT, 6'd2), 4, C_CVT, 6'd2);
        exp_q.push_back(e);
        exp_q.push_back(sl(ex("R8"), 0, C_ALU, 6'd3));
        run();

        // R9: an invalid lane ends the bundle even with valid lanes behind it
        stim.push_back(mk(C_ALU, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        stim.push_back(hole());
        stim.push_back(mk(C_ALU, 6'd2, 6'd41, 6'd0, 3'b001, 2'd0));
        exp_q.push_back(sl(ex("R9"), 0, C_ALU, 6'd1));
        exp_q.push_back(sl(ex("R9"), 0, C_ALU, 6'd2));
        run();

        // R1: reciprocal offered during reset leaves no hold behind
        @(negedge clk);
        clear_inputs();
        put_lane(0, mk(C_RCP, 6'd1, 6'd40, 6'd0, 3'b001, 2'd0));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(out_vld == '0 && out_eob == 1'b0, "R1",
              $sformatf("after reset actual vld=%b eob=%b expected 0 0", out_vld, out_eob));
        clear_inputs();
        put_lane(0, mk(C_ALU, 6'd2, 6'd41, 6'd0, 3'b001, 2'd0));
        #1;
        check(in_ready == 5'b00001, "R1",
              $sformatf("actual in_ready=%b expected 00001", in_ready));
        @(negedge clk);
        check(out_vld == 5'b00001 && out_dst[RW-1:0] == 6'd2 && out_eob, "R1",
              $sformatf("actual vld=%b dst0=%0d expected 00001 2", out_vld, out_dst[RW-1:0]));
        clear_inputs();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule